// File: doc/BRIEF.md
# Interlocked flash mode control register

This block holds the 8-bit control word that puts an on-chip flash array into one of its operating modes: program, erase, program-verify or erase-verify. A hardware write-enable pin sets the top bit and protects the array. The other seven bits form a chain of interlocks. A software enable must be set first. The setup and verify bits can only be set after that, and the two action bits (program pulse, erase pulse) each need their own setup bit already set. A mode can therefore only be reached by writing the bits in order, one write per step.

The register sits on a simple write/read port. While the flash is disabled, it reads as zero and ignores writes. It is cleared by reset, by either of two standby inputs, and by the pin going low. Four one-hot outputs give the active mode to the array sequencer.

Top module: `flash_mode_ctl`

## Requirements
- R1: Bit positions are bit 7 hardware enable (read-only), bit 6 software enable, bit 5 erase setup, bit 4 program setup, bit 3 erase-verify, bit 2 program-verify, bit 1 erase, bit 0 program. Bit 7 reads the pin level sampled at the last clock, and writes to bit 7 have no effect.
- R2: The software enable (bit 6) takes a written value only while bit 7 reads 1.
- R3: Bits 5, 4, 3 and 2 take a written value only while bits 7 and 6 both read 1 before the write.
- R4: Bit 1 takes a write only if bits 7, 6 and 5 read 1 before the write. Bit 0 takes a write only if bits 7, 6 and 4 read 1 before the write. A single write that sets a prerequisite and its dependent bit together sets only the prerequisite.
- R5: In a write, a bit whose condition is false keeps its old value, and the enabled bits in the same write still update.
- R6: When bit 6 becomes 0, bits 5 to 0 become 0 at the same clock edge.
- R7: With the pin low at a clock edge, bits 7 to 0 read 0 after that edge, and writes have no effect.
- R8: The asynchronous active-low reset, a high hardware standby input or a high software standby input clears bits 6 to 0. After this the register reads 0x80 with the pin high and 0x00 with it low. Writes during standby have no effect.
- R9: While the flash-disabled input is high, the read port returns 0x00 and writes have no effect. The held contents reappear when the input returns low.
- R10: The mode outputs are one-hot or all zero, with the priority program (bit 0) over erase (bit 1) over program-verify (bit 2) over erase-verify (bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_standby_i | input | 1 | Hardware standby, clears the register while high |
| sw_standby_i | input | 1 | Software standby, clears the register while high |
| wen_pin_i | input | 1 | Hardware write-enable pin level |
| flash_off_i | input | 1 | Flash disabled: reads zero, writes ignored |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read value |
| prog_o | output | 1 | Program mode active |
| erase_o | output | 1 | Erase mode active |
| prog_vfy_o | output | 1 | Program-verify mode active |
| erase_vfy_o | output | 1 | Erase-verify mode active |

## Verification
The interlock is driven with the proper setup-then-action sequences and with every order of four single-bit writes, on both the program side and the erase side. Only the proper order ends in the mode. The other orders show whether each enable is judged on the contents before the write. Writes that set several bits at once separate per-bit gating from all-or-nothing gating. Pin drops, standby pulses, writes to bit 7 and writes while the flash is disabled show which clear or protection path acts. A long pseudo-random write stream with occasional pin drops is compared against a reference model.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam int FMC_W   = 8;
  localparam int B_HWE   = 7;
  localparam int B_SWE   = 6;
  localparam int B_ESU   = 5;
  localparam int B_PSU   = 4;
  localparam int B_EVF   = 3;
  localparam int B_PVF   = 2;
  localparam int B_ERS   = 1;
  localparam int B_PRG   = 0;
  localparam int N_MODE  = 4;
  localparam int RST_STG = 2;
endpackage

// File: rtl/fmc_rst_sync.sv
module fmc_rst_sync #(
  parameter int STAGES = fmc_pkg::RST_STG
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/fmc_wr_gate.sv
module fmc_wr_gate #(
  parameter int W = fmc_pkg::FMC_W
) (
  input  logic         hwe,
  input  logic         swe,
  input  logic         esu,
  input  logic         psu,
  output logic [W-1:0] wmask
);
  import fmc_pkg::*;

  logic base_ok;

  always_comb begin
    base_ok        = hwe & swe;
    wmask          = '0;
    wmask[B_HWE]   = 1'b0;
    wmask[B_SWE]   = hwe;
    wmask[B_ESU]   = base_ok;
    wmask[B_PSU]   = base_ok;
    wmask[B_EVF]   = base_ok;
    wmask[B_PVF]   = base_ok;
    wmask[B_ERS]   = base_ok & esu;
    wmask[B_PRG]   = base_ok & psu;
  end
endmodule

// File: rtl/fmc_ctl_reg.sv
module fmc_ctl_reg #(
  parameter int W = fmc_pkg::FMC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic         stby,
  input  logic         flash_off,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);
  import fmc_pkg::*;

  localparam int LW = W - 1;

  logic          hwe_q;
  logic [LW-1:0] bits_q;
  logic [W-1:0]  nxt;
  logic          wr_act;
  logic          clr;
  logic          ld_en;

  assign q = {hwe_q, bits_q};

  always_comb begin
    wr_act = wr_en & ~flash_off;
    clr    = stby | ~pin;
    ld_en  = wr_act | clr;
    nxt    = q;
    if (wr_act) begin
      for (int i = 0; i < W; i++) begin
        if (wmask[i]) nxt[i] = wr_data[i];
      end
    end
    if (!nxt[B_SWE]) nxt[B_SWE-1:0] = '0;
    if (clr)         nxt[LW-1:0]    = '0;
    nxt[W-1] = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bits_q <= '0;
    else if (ld_en) bits_q <= nxt[LW-1:0];
  end

  always_ff @(posedge clk) begin
    hwe_q <= nxt[W-1];
  end
endmodule

// File: rtl/fmc_mode_dec.sv
module fmc_mode_dec #(
  parameter int N = fmc_pkg::N_MODE
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] onehot
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_pri
    assign onehot[g]  = req[g] & ~taken[g];
    assign taken[g+1] = taken[g] | req[g];
  end
endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl #(
  parameter int W = fmc_pkg::FMC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_standby_i,
  input  logic         sw_standby_i,
  input  logic         wen_pin_i,
  input  logic         flash_off_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  output logic         prog_o,
  output logic         erase_o,
  output logic         prog_vfy_o,
  output logic         erase_vfy_o
);
  import fmc_pkg::*;

  logic                rst_int_n;
  logic [W-1:0]        ctl_q;
  logic [W-1:0]        wmask;
  logic [N_MODE-1:0]   mode_oh;
  logic                stby;

  assign stby = hw_standby_i | sw_standby_i;

  fmc_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fmc_wr_gate #(.W(W)) u_gate (
    .hwe   (ctl_q[B_HWE]),
    .swe   (ctl_q[B_SWE]),
    .esu   (ctl_q[B_ESU]),
    .psu   (ctl_q[B_PSU]),
    .wmask (wmask)
  );

  fmc_ctl_reg #(.W(W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin       (wen_pin_i),
    .stby      (stby),
    .flash_off (flash_off_i),
    .wr_en     (wr_en_i),
    .wr_data   (wr_data_i),
    .wmask     (wmask),
    .q         (ctl_q)
  );

  // request bits ordered by priority: program, erase, program-verify, erase-verify
  fmc_mode_dec #(.N(N_MODE)) u_dec (
    .req    ({ctl_q[B_EVF], ctl_q[B_PVF], ctl_q[B_ERS], ctl_q[B_PRG]}),
    .onehot (mode_oh)
  );

  assign rd_data_o   = flash_off_i ? '0 : ctl_q;
  assign prog_o      = mode_oh[0];
  assign erase_o     = mode_oh[1];
  assign prog_vfy_o  = mode_oh[2];
  assign erase_vfy_o = mode_oh[3];
endmodule

// File: rtl/fmc_checker.sv
module fmc_checker #(
  parameter int W = fmc_pkg::FMC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pin,
  input logic         stby,
  input logic         flash_off,
  input logic [W-1:0] ctl_q,
  input logic [W-1:0] rd,
  input logic [3:0]   modes
);
  import fmc_pkg::*;

  a_r2_swe_needs_hwe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[B_SWE]) |-> $past(ctl_q[B_HWE]));

  a_r3_setup_needs_swe: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_q[B_ESU]) || $rose(ctl_q[B_PSU]) || $rose(ctl_q[B_EVF]) || $rose(ctl_q[B_PVF]))
      |-> $past(ctl_q[B_SWE] && ctl_q[B_HWE]));

  a_r4_prg_needs_psu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[B_PRG]) |-> $past(ctl_q[B_PSU] && ctl_q[B_SWE]));

  a_r4_ers_needs_esu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[B_ERS]) |-> $past(ctl_q[B_ESU] && ctl_q[B_SWE]));

  a_r6_swe_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[B_SWE]) |-> (ctl_q[B_SWE-1:0] == '0));

  a_r7_pin_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pin |=> (ctl_q == '0));

  a_r8_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (ctl_q[W-2:0] == '0));

  a_r9_off_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flash_off |-> (rd == '0));

  a_r9_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flash_off) && !$past(stby) && $past(pin)) |-> (ctl_q[W-2:0] == $past(ctl_q[W-2:0])));

  a_r10_modes_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(modes));
endmodule

bind flash_mode_ctl fmc_checker #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin       (wen_pin_i),
  .stby      (stby),
  .flash_off (flash_off_i),
  .ctl_q     (ctl_q),
  .rd        (rd_data_o),
  .modes     ({erase_vfy_o, prog_vfy_o, erase_o, prog_o})
);

// File: tb/flash_mode_ctl_tb_top.sv
module flash_mode_ctl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       hw_stby;
  logic       sw_stby;
  logic       pin;
  logic       foff;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd;
  logic       m_prg, m_ers, m_pvf, m_evf;

  int  n_chk;
  int  n_err;
  bit  done;
  logic [6:0] st;  // model of bits 6..0

  flash_mode_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .hw_standby_i(hw_stby), .sw_standby_i(sw_stby),
    .wen_pin_i(pin), .flash_off_i(foff), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .prog_o(m_prg), .erase_o(m_ers), .prog_vfy_o(m_pvf),
    .erase_vfy_o(m_evf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [6:0] mdl_write(logic [6:0] c, logic hwe, logic [7:0] d);
    logic [6:0] n;
    logic ok;
    n  = c;
    ok = hwe & c[6];
    if (hwe)       n[6] = d[6];
    if (ok)        n[5:2] = d[5:2];
    if (ok & c[5]) n[1] = d[1];
    if (ok & c[4]) n[0] = d[0];
    if (!n[6])     n[5:0] = '0;
    return n;
  endfunction

  function automatic logic [3:0] mdl_mode(logic [6:0] s);
    if (s[0]) return 4'b0001;
    if (s[1]) return 4'b0010;
    if (s[2]) return 4'b0100;
    if (s[3]) return 4'b1000;
    return 4'b0000;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(req, rd, {pin, st});
    chk({req, " mode"}, {4'b0, m_evf, m_pvf, m_ers, m_prg}, {4'b0, mdl_mode(st)});
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (pin && !foff && !hw_stby && !sw_stby) st = mdl_write(st, 1'b1, d);
    else if (!pin || hw_stby || sw_stby)      st = '0;
  endtask

  task automatic do_reset(logic p);
    @(negedge clk);
    pin = p; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    st = '0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R8 reset pin high", rd, 8'h80);
    chk("R10 reset modes", {4'b0, m_evf, m_pvf, m_ers, m_prg}, 8'h00);
    do_reset(1'b0);
    chk("R8 reset pin low", rd, 8'h00);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    chk("R1 bit7 follows pin", rd, 8'h80);
  endtask

  task automatic t_program();
    wr(8'h40); chk_state("R2 swe set");
    wr(8'h50); chk_state("R3 psu set");
    wr(8'h51); chk_state("R4 program entry");
    chk("R10 program out", {7'b0, m_prg}, 8'h01);
    wr(8'h00); chk_state("R6 swe clear");
  endtask

  task automatic t_erase();
    wr(8'h40); wr(8'h60); wr(8'h62);
    chk_state("R4 erase entry");
    chk("R10 erase out", {7'b0, m_ers}, 8'h01);
    wr(8'h22); chk("R6 swe clear erase", rd, 8'h80);
    st = '0;
  endtask

  task automatic t_verify();
    wr(8'h40); wr(8'h44); chk_state("R3 pverify");
    chk("R10 pverify out", {7'b0, m_pvf}, 8'h01);
    wr(8'h48); chk_state("R3 everify");
    chk("R10 everify out", {7'b0, m_evf}, 8'h01);
    wr(8'h4C); chk_state("R10 pverify over everify");
    wr(8'h00);
  endtask

  task automatic t_same_write();
    wr(8'h7F); chk("R4 same write only swe", rd, 8'hC0);
    wr(8'h73); chk("R5 partial write", rd, 8'hF0);
    wr(8'h73); chk("R4 action after setup", rd, 8'hF3);
    chk("R10 program over erase", {4'b0, m_evf, m_pvf, m_ers, m_prg}, 8'h01);
    wr(8'h00); chk("R1 bit7 write ignored", rd, 8'h80);
    st = '0;
  endtask

  task automatic t_pin_low();
    wr(8'h40); wr(8'h50); wr(8'h51);
    @(negedge clk); pin = 1'b0;
    @(negedge clk);
    chk("R7 pin low clears", rd, 8'h00);
    st = '0;
    wr(8'h40);
    chk("R7 write pin low", rd, 8'h00);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    chk("R2 after pin restore", rd, 8'h80);
  endtask

  task automatic t_standby();
    wr(8'h40); wr(8'h60);
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0;
    chk("R8 hw standby clears", rd, 8'h80);
    st = '0;
    wr(8'h40); wr(8'h50);
    @(negedge clk); sw_stby = 1'b1;
    wr(8'h40);
    chk("R8 write in standby", rd, 8'h80);
    sw_stby = 1'b0;
    @(negedge clk);
    chk("R8 sw standby clears", rd, 8'h80);
    st = '0;
  endtask

  task automatic t_flash_off();
    wr(8'h40); wr(8'h50);
    @(negedge clk); foff = 1'b1;
    @(negedge clk);
    chk("R9 off reads zero", rd, 8'h00);
    wr(8'h00);
    @(negedge clk); foff = 1'b0;
    @(negedge clk);
    chk("R9 off write ignored", rd, 8'hD0);
    wr(8'h00);
  endtask

  task automatic run_order(int b0, int b1, int b2, int b3, string req);
    int bits[4];
    logic [7:0] acc;
    bits = '{b0, b1, b2, b3};
    acc = 8'h00;
    for (int k = 0; k < 4; k++) begin
      acc[bits[k]] = 1'b1;
      wr(acc);
      chk_state(req);
    end
    wr(8'h00);
  endtask

  task automatic t_permute();
    int pr[4];
    int er[4];
    pr = '{6, 4, 0, 2};
    er = '{6, 5, 1, 3};
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              run_order(pr[a], pr[b], pr[c], pr[d], "R4 program order");
              run_order(er[a], er[b], er[c], er[d], "R3 erase order");
            end
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 16) == 0) begin
        @(negedge clk); pin = 1'b0;
        @(negedge clk); st = '0;
        chk_state("R7 random pin drop");
        pin = 1'b1;
        @(negedge clk);
      end
      wr(8'($urandom) | ((($urandom % 4) != 0) ? 8'h40 : 8'h00));
      chk_state("R5 random write");
    end
  endtask

  initial begin
    rst_n = 1'b0; hw_stby = 1'b0; sw_stby = 1'b0; pin = 1'b1;
    foff = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    n_chk = 0; n_err = 0; done = 1'b0; st = '0;
    t_reset();
    t_program();
    t_erase();
    t_verify();
    t_same_write();
    t_pin_low();
    t_standby();
    t_flash_off();
    t_permute();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule